// File: doc/BRIEF.md
# Serial Bit-Clock Source Auto-Selector

This block decides which bit clock an audio serial port runs on. It watches a raw bit clock from outside against the left/right frame clock. Both are sampled in the master-clock domain. When the outside bit clock is active, the block passes it through. When the outside bit clock is silent, the block makes its own bit clock by dividing the master clock.

Edge activity alone picks the source, so no register has to be written. For every frame-clock phase, high or low, the block counts the rising bit-clock edges in that phase. A phase that holds enough edges switches the block to the outside clock. A run of frame-clock phases with no edge at all sends it back to the generated clock. The mode flag can change only at a frame-clock transition, so no frame is ever split between two clock sources.

While the generated clock is in use, the number of bit clocks per frame follows from the master-to-frame ratio code and the format code. The divider phase is reset at each frame-clock transition.

Top module: `sclk_auto_select`

## Requirements
- R1: After reset is released, `ext_mode` is 0 and `bclk_out` carries the internally generated clock.
- R2: When a single frame-clock phase holds 16 rising edges of `bclk_in`, `ext_mode` becomes 1 within 4 master cycles of the frame-clock transition that closes that phase.
- R3: A phase holding 15 or fewer rising edges leaves `ext_mode` at 0.
- R4: Edge counting works the same in a phase where `fclk_in` is high and in a phase where it is low.
- R5: The count restarts at every frame-clock transition, so 8 edges in one phase plus 8 in the next do not trigger external mode.
- R6: In external mode, four back-to-back frame-clock phases (two full frames) with no rising edge on `bclk_in` return `ext_mode` to 0. Three quiet phases followed by a phase with any edge keep it at 1.
- R7: `ext_mode` changes only in the master cycle after a detected frame-clock transition. Having 16 edges mid-phase does not change it before the phase ends.
- R8: While `ext_mode` is 1, `bclk_out` equals `bclk_in`.
- R9: `ratio_sel` codes give these master-to-frame ratios: 0 = 128, 1 = 192, 2 = 256, 3 = 384, 4 to 7 = 512. In internal mode with ratio 384 or 192, `bclk_out` gives 48 rising edges per frame for any `fmt_sel`.
- R10: In internal mode with ratio 128, 256 or 512, `fmt_sel` = 0 gives 64 rising edges per frame and any other `fmt_sel` code gives 32.
- R11: A rising bit-clock edge that reaches the detector in the same master cycle as a frame-clock transition is counted in the phase that is ending.
- R12: In internal mode, the master cycle after a detected frame-clock transition restarts the generated clock low. It then stays low for half a bit period before it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_in | input | 1 | Raw bit clock from outside, asynchronous |
| fclk_in | input | 1 | Raw left/right frame clock, asynchronous |
| fmt_sel | input | 3 | Interface format code; 0 selects the 64-bit frame |
| ratio_sel | input | 3 | Master-to-frame clock ratio code |
| bclk_out | output | 1 | Selected bit clock |
| ext_mode | output | 1 | 1 when the outside bit clock is selected |

## Verification
Two functions can land in the same master cycle: counting a rising bit-clock edge, and closing a phase at a frame-clock transition. The bench provokes this by driving the 16th bit-clock rise at the same instant as the frame-clock toggle. Both signals pass through synchronizers of equal depth, so they reach the detector together. The outcome is judged by whether `ext_mode` rises at that transition, which shows the edge was credited to the ending phase and not dropped or moved to the next phase.

// File: rtl/sclk_sel_pkg.sv
package sclk_sel_pkg;

  typedef enum logic [2:0] {
    MR_128 = 3'd0,
    MR_192 = 3'd1,
    MR_256 = 3'd2,
    MR_384 = 3'd3,
    MR_512 = 3'd4
  } mclk_ratio_e;

  localparam int HALF_W = 4;

  // Master cycles per half bit period = ratio / (bits per frame) / 2
  function automatic logic [HALF_W-1:0] half_period(input logic [2:0] ratio,
                                                     input logic [2:0] fmt);
    logic wide_frame;
    wide_frame = (fmt == 3'd0);
    case (mclk_ratio_e'(ratio))
      MR_128:  half_period = wide_frame ? 4'd1 : 4'd2;
      MR_192:  half_period = 4'd2;
      MR_256:  half_period = wide_frame ? 4'd2 : 4'd4;
      MR_384:  half_period = 4'd4;
      default: half_period = wide_frame ? 4'd4 : 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sclk_activity.sv
module sclk_activity #(
  parameter int ENTRY_EDGES   = 16,
  parameter int QUIET_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_rise,
  input  logic fr_edge,
  output logic ext_mode
);

  localparam int CNT_W    = $clog2(ENTRY_EDGES + 1);
  localparam int QUIET_PH = 2 * QUIET_PERIODS;
  localparam int Q_W      = $clog2(QUIET_PH + 1);
  localparam logic [CNT_W-1:0] HIT_MAX   = CNT_W'(ENTRY_EDGES);
  localparam logic [Q_W-1:0]   QUIET_MAX = Q_W'(QUIET_PH);

  logic [CNT_W-1:0] hit_q, hit_d, phase_hits;
  logic [Q_W-1:0]   quiet_q, quiet_d, quiet_next;
  logic             ext_q, ext_d;
  logic             upd_en;

  // hits of the current phase including an edge arriving this cycle
  always_comb begin
    phase_hits = hit_q;
    if (bclk_rise && (hit_q != HIT_MAX)) phase_hits = hit_q + 1'b1;
  end

  always_comb begin
    if (phase_hits != '0)        quiet_next = '0;
    else if (quiet_q == QUIET_MAX) quiet_next = quiet_q;
    else                         quiet_next = quiet_q + 1'b1;
  end

  always_comb begin
    hit_d   = phase_hits;
    quiet_d = quiet_q;
    ext_d   = ext_q;
    if (fr_edge) begin
      hit_d   = '0;
      quiet_d = quiet_next;
      if (!ext_q && (phase_hits == HIT_MAX))       ext_d = 1'b1;
      else if (ext_q && (quiet_next == QUIET_MAX)) ext_d = 1'b0;
    end
  end

  assign upd_en = fr_edge | bclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= '0;
      quiet_q <= '0;
      ext_q   <= 1'b0;
    end else if (upd_en) begin
      hit_q   <= hit_d;
      quiet_q <= quiet_d;
      ext_q   <= ext_d;
    end
  end

  assign ext_mode = ext_q;

endmodule

// File: rtl/sclk_int_gen.sv
module sclk_int_gen #(
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              realign,
  input  logic [HALF_W-1:0] half,
  output logic              bclk_int
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              bclk_q, bclk_d;
  logic              wrap;

  assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, half};

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    bclk_d = bclk_q;
    if (realign) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk_int = bclk_q;

endmodule

// File: rtl/sclk_auto_select.sv
module sclk_auto_select #(
  parameter int ENTRY_EDGES   = 16,
  parameter int QUIET_PERIODS = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       bclk_in,
  input  logic       fclk_in,
  input  logic [2:0] fmt_sel,
  input  logic [2:0] ratio_sel,
  output logic       bclk_out,
  output logic       ext_mode
);

  import sclk_sel_pkg::*;

  logic                rst_sync_n;
  logic [1:0]          raw_pair, sync_pair;
  logic                bclk_s, fclk_s, bclk_p, fclk_p;
  logic                bclk_rise, fr_edge;
  logic                bclk_int;
  logic [HALF_W-1:0]   half;

  sclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(mclk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  assign raw_pair = {fclk_in, bclk_in};

  sclk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(mclk), .rst_n(rst_sync_n), .d(raw_pair), .q(sync_pair)
  );

  assign bclk_s = sync_pair[0];
  assign fclk_s = sync_pair[1];

  always_ff @(posedge mclk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bclk_p <= 1'b0;
      fclk_p <= 1'b0;
    end else begin
      bclk_p <= bclk_s;
      fclk_p <= fclk_s;
    end
  end

  assign bclk_rise = bclk_s & ~bclk_p;
  assign fr_edge   = fclk_s ^ fclk_p;

  sclk_activity #(.ENTRY_EDGES(ENTRY_EDGES), .QUIET_PERIODS(QUIET_PERIODS)) u_act (
    .clk(mclk), .rst_n(rst_sync_n), .bclk_rise(bclk_rise),
    .fr_edge(fr_edge), .ext_mode(ext_mode)
  );

  assign half = half_period(ratio_sel, fmt_sel);

  sclk_int_gen #(.HALF_W(HALF_W)) u_gen (
    .clk(mclk), .rst_n(rst_sync_n), .realign(fr_edge),
    .half(half), .bclk_int(bclk_int)
  );

  assign bclk_out = ext_mode ? bclk_in : bclk_int;

endmodule

// File: rtl/sclk_auto_select_chk.sv
module sclk_auto_select_chk #(
  parameter int ENTRY_EDGES   = 16,
  parameter int QUIET_PERIODS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic fr_edge,
  input logic bclk_rise,
  input logic bclk_int,
  input logic bclk_in,
  input logic bclk_out,
  input logic ext_mode
);

  logic [7:0] ck_cnt, ck_hits, ck_quiet;

  assign ck_hits = ck_cnt + {7'd0, bclk_rise};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt   <= '0;
      ck_quiet <= '0;
    end else if (fr_edge) begin
      ck_cnt   <= '0;
      ck_quiet <= (ck_hits != 0) ? 8'd0 : ((ck_quiet < 8'd200) ? ck_quiet + 8'd1 : ck_quiet);
    end else if (bclk_rise && ck_cnt < 8'd200) begin
      ck_cnt <= ck_cnt + 8'd1;
    end
  end

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fr_edge && !ext_mode && (ck_hits >= ENTRY_EDGES) |=> ext_mode);

  p_stay_internal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fr_edge && !ext_mode && (ck_hits < ENTRY_EDGES) |=> !ext_mode);

  p_quiet_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fr_edge && ext_mode && (ck_hits == 0) && (ck_quiet == 2*QUIET_PERIODS-1) |=> !ext_mode);

  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fr_edge && ext_mode && (ck_hits != 0) |=> ext_mode);

  p_edge_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_mode) |-> $past(fr_edge));

  p_pass_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (bclk_out == bclk_in));

  p_realign_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fr_edge |=> !bclk_int);

endmodule

bind sclk_auto_select sclk_auto_select_chk #(
  .ENTRY_EDGES(ENTRY_EDGES), .QUIET_PERIODS(QUIET_PERIODS)
) u_chk (
  .clk(mclk), .rst_n(rst_sync_n), .fr_edge(fr_edge), .bclk_rise(bclk_rise),
  .bclk_int(bclk_int), .bclk_in(bclk_in), .bclk_out(bclk_out), .ext_mode(ext_mode)
);

// File: tb/sclk_auto_select_test.sv
module sclk_auto_select_test;

  localparam int CLK_PERIOD = 10;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk_in = 1'b0;
  logic       fclk_in = 1'b0;
  logic [2:0] fmt_sel = 3'd0;
  logic [2:0] ratio_sel = 3'd4;
  logic       bclk_out;
  logic       ext_mode;

  int n_chk = 0;
  int n_bad = 0;

  sclk_auto_select uut (
    .mclk(mclk), .rst_n(rst_n), .bclk_in(bclk_in), .fclk_in(fclk_in),
    .fmt_sel(fmt_sel), .ratio_sel(ratio_sel), .bclk_out(bclk_out), .ext_mode(ext_mode)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic toggle_fclk();
    fclk_in = ~fclk_in;
    tick(6);
  endtask

  task automatic start_phase(input logic lvl);
    if (fclk_in == lvl) toggle_fclk();
    toggle_fclk();
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      bclk_in = 1'b1; tick(2);
      bclk_in = 1'b0; tick(2);
    end
  endtask

  task automatic t_reset();
    tick(1);
    check(ext_mode == 1'b0, "R1 ext_mode in reset", ext_mode, 0);
    rst_n = 1'b1;
    tick(6);
    check(ext_mode == 1'b0, "R1 ext_mode after reset", ext_mode, 0);
  endtask

  task automatic t_below();
    start_phase(1'b0);
    pulses(15);
    toggle_fclk();
    check(ext_mode == 1'b0, "R3 15 edges stay internal", ext_mode, 0);
  endtask

  task automatic t_split();
    start_phase(1'b1);
    pulses(8);
    toggle_fclk();
    pulses(8);
    toggle_fclk();
    check(ext_mode == 1'b0, "R5 split edges do not add", ext_mode, 0);
  endtask

  task automatic t_entry_low_and_exit();
    start_phase(1'b0);
    pulses(16);
    check(ext_mode == 1'b0, "R7 no switch mid-phase", ext_mode, 0);
    toggle_fclk();
    check(ext_mode == 1'b1, "R2 R4 entry in low phase", ext_mode, 1);
    repeat (3) toggle_fclk();
    check(ext_mode == 1'b1, "R6 three quiet phases hold", ext_mode, 1);
    bclk_in = 1'b1; tick(1);
    check(bclk_out == 1'b1, "R8 pass-through high", bclk_out, 1);
    tick(1); bclk_in = 1'b0; tick(1);
    check(bclk_out == 1'b0, "R8 pass-through low", bclk_out, 0);
    tick(1);
    toggle_fclk();
    check(ext_mode == 1'b1, "R6 active phase resets quiet run", ext_mode, 1);
    repeat (3) toggle_fclk();
    check(ext_mode == 1'b1, "R6 still held after three", ext_mode, 1);
    toggle_fclk();
    check(ext_mode == 1'b0, "R6 exit after two quiet frames", ext_mode, 0);
  endtask

  task automatic t_entry_high();
    start_phase(1'b1);
    pulses(16);
    toggle_fclk();
    check(ext_mode == 1'b1, "R4 entry in high phase", ext_mode, 1);
    repeat (4) toggle_fclk();
    check(ext_mode == 1'b0, "R6 exit after high entry", ext_mode, 0);
  endtask

  task automatic t_coincide();
    start_phase(1'b0);
    pulses(15);
    bclk_in = 1'b1;
    fclk_in = ~fclk_in;
    tick(2);
    bclk_in = 1'b0;
    tick(6);
    check(ext_mode == 1'b1, "R11 coincident edge counted", ext_mode, 1);
    repeat (4) toggle_fclk();
    check(ext_mode == 1'b0, "R11 exit afterwards", ext_mode, 0);
  endtask

  function automatic int ratio_val(input logic [2:0] code);
    case (code)
      3'd0: return 128;
      3'd1: return 192;
      3'd2: return 256;
      3'd3: return 384;
      default: return 512;
    endcase
  endfunction

  task automatic t_ratio(input logic [2:0] rc, input logic [2:0] fc, input int bits, input string req);
    int ratio;
    int rises;
    logic prev;
    ratio = ratio_val(rc);
    ratio_sel = rc;
    fmt_sel = fc;
    rises = 0;
    prev = 1'b0;
    for (int c = 0; c < 3*ratio; c++) begin
      @(negedge mclk);
      if (c >= 2*ratio && bclk_out && !prev) rises++;
      prev = bclk_out;
      if (c % (ratio/2) == 0) fclk_in = ~fclk_in;
    end
    check(rises == bits, req, rises, bits);
    check(ext_mode == 1'b0, "R1 internal during ratio run", ext_mode, 0);
  endtask

  task automatic t_realign();
    int low_bad;
    ratio_sel = 3'd4;
    fmt_sel = 3'd5;
    low_bad = 0;
    tick(37);
    fclk_in = ~fclk_in;
    for (int k = 1; k <= 11; k++) begin
      tick(1);
      if (k >= 3 && k <= 10 && bclk_out !== 1'b0) low_bad++;
      if (k == 11) check(bclk_out == 1'b1, "R12 first rise after half period", bclk_out, 1);
    end
    check(low_bad == 0, "R12 low after realign", low_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge mclk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    t_below();
    t_split();
    t_entry_low_and_exit();
    t_entry_high();
    t_coincide();
    t_ratio(3'd3, 3'd0, 48, "R9 ratio 384 gives 48");
    t_ratio(3'd1, 3'd2, 48, "R9 ratio 192 gives 48");
    t_ratio(3'd4, 3'd0, 64, "R10 ratio 512 fmt0 gives 64");
    t_ratio(3'd2, 3'd0, 64, "R10 ratio 256 fmt0 gives 64");
    t_ratio(3'd0, 3'd0, 64, "R10 ratio 128 fmt0 gives 64");
    t_ratio(3'd4, 3'd5, 32, "R10 ratio 512 other fmt gives 32");
    t_ratio(3'd2, 3'd1, 32, "R10 ratio 256 other fmt gives 32");
    t_ratio(3'd0, 3'd3, 32, "R10 ratio 128 other fmt gives 32");
    t_realign();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule